// File: doc/BRIEF.md
# Reference-Counted Multicast Hash Filter

This block keeps the 64-bit group-address filter of an Ethernet receiver. A host adds or removes 48-bit multicast addresses one at a time. For each command the block hashes the address with a bit-serial CRC down to a 6-bit bin number. It keeps an 8-bit use count for every bin, and changes the filter bit of a bin only when that bin gains its first user or loses its last one. Removing one address therefore leaves the bit set while another address that hashes to the same bin is still registered.

A sync command copies the filter to the receiver's filter register. The block raises an access request and waits for a grant. It then writes the eight filter bytes, one per cycle, lowest byte first, into a single byte-wide data port. A lookup port tests a destination address against the current filter, so receive logic can check whether a frame falls in a wanted bin.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset all bin counts and filter bits are zero, `busy_o`, `err_o`, `acc_req_o`, `wr_en_o` and `lookup_hit_o` are low, and a sync after reset writes eight zero bytes.
- R2: The bin of an address comes from a CRC with polynomial 0x04C11DB7, seeded with all ones. The address is split into three 16-bit words and fed high word first (bits 47:32, then 31:16, then 15:0). The two bytes of each word are swapped, and the swapped word is fed least significant bit first. At each step the register shifts left, and it is XORed with the polynomial when its old MSB differs from the data bit. The bin is the low 6 CRC bits in reversed order, and its filter bit is bit bin%8 of filter byte bin/8.
- R3: Add (`cmd_op_i` = 2'b00) increments the bin count and sets the filter bit when the count goes from zero to one.
- R4: Remove (`cmd_op_i` = 2'b01) decrements a non-zero count and clears the filter bit only when the count reaches zero, so a bin shared by two addresses stays set until both are removed.
- R5: Remove against a zero count changes nothing and raises `err_o` for exactly one cycle, in the cycle `busy_o` falls.
- R6: A bin count saturates at 255. Adds beyond that leave it at 255, so 256 adds followed by 255 removes leave the bit clear.
- R7: An accepted add or remove keeps `busy_o` high for 49 cycles, starting in the cycle after acceptance. Commands presented while `busy_o` is high are ignored, and `cmd_op_i` = 2'b11 is ignored and never raises `busy_o`.
- R8: Sync (`cmd_op_i` = 2'b10) raises `acc_req_o` and writes nothing until `acc_gnt_i` is seen. The cycle after the grant, it writes filter bytes 0 to 7 on eight consecutive cycles through `wr_en_o`/`wr_data_o`, and then drops `busy_o`.
- R9: `lookup_hit_o` is registered. One cycle after `lookup_valid_i` it equals the filter bit of the bin of `lookup_addr_i`, and it is low in any cycle that follows one where `lookup_valid_i` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, taken when `busy_o` is low |
| cmd_op_i | input | 2 | 00 add, 01 remove, 10 sync, 11 no-op |
| cmd_addr_i | input | 48 | Group address for add or remove |
| busy_o | output | 1 | Command in progress |
| err_o | output | 1 | One-cycle pulse: remove hit a zero count |
| acc_req_o | output | 1 | Request for filter-register write access |
| acc_gnt_i | input | 1 | Access granted |
| wr_en_o | output | 1 | Filter byte write strobe |
| wr_data_o | output | 8 | Filter byte being written |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_addr_i | input | 48 | Destination address to test |
| lookup_hit_o | output | 1 | Bin of the looked-up address is set |

## Verification
The hardest case to reach is a bin shared by two distinct addresses. Only that case shows whether a remove clears a bit that another address still holds. Random addresses rarely collide, so the bench searches random addresses with its own hash function until it finds a partner for a chosen address. It then interleaves adds and removes of the pair. Saturation is reached with 256 adds of one address followed by the matching removes. A random mix over a small address pool keeps several bins shared throughout the run.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int ADDR_W    = 48;
  localparam int IDX_W     = 6;
  localparam int NBINS     = 1 << IDX_W;
  localparam int NBYTES    = NBINS / 8;
  localparam int CRC_W     = 32;
  localparam int WORD_W    = 16;
  localparam int NWORDS    = ADDR_W / WORD_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_REM  = 2'b01,
    OP_SYNC = 2'b10,
    OP_NOP  = 2'b11
  } op_e;

  // bit k of the result is the k-th bit fed into the CRC
  function automatic logic [ADDR_W-1:0] feed_order(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] s;
    logic [WORD_W-1:0] w;
    s = '0;
    for (int j = 0; j < NWORDS; j++) begin
      w = a[ADDR_W-1-WORD_W*j -: WORD_W];
      s[WORD_W*j +: WORD_W] = {w[7:0], w[15:8]};
    end
    return s;
  endfunction

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic d);
    logic fb;
    fb = c[CRC_W-1] ^ d;
    c = {c[CRC_W-2:0], 1'b0};
    if (fb) c = c ^ CRC_POLY;
    return c;
  endfunction

  function automatic logic [IDX_W-1:0] bin_of_crc(input logic [CRC_W-1:0] c);
    logic [IDX_W-1:0] r;
    for (int i = 0; i < IDX_W; i++) r[i] = c[IDX_W-1-i];
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] bin_of_addr(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] s;
    logic [CRC_W-1:0] c;
    s = feed_order(a);
    c = '1;
    for (int k = 0; k < ADDR_W; k++) c = crc_step(c, s[k]);
    return bin_of_crc(c);
  endfunction
endpackage

// File: rtl/mhf_crc_serial.sv
module mhf_crc_serial
  import mhf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              done_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int STEPS  = ADDR_W;
  localparam int CNT_W  = $clog2(STEPS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  logic [ADDR_W-1:0] sh_q;
  logic [CRC_W-1:0]  crc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              run_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      crc_q  <= '1;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      sh_q   <= feed_order(addr_i);
      crc_q  <= '1;
      cnt_q  <= '0;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= run_q && (cnt_q == LAST);
      if (run_q) begin
        crc_q <= crc_step(crc_q, sh_q[0]);
        sh_q  <= sh_q >> 1;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) run_q <= 1'b0;
      end
    end
  end

  assign done_o = done_q;
  assign idx_o  = bin_of_crc(crc_q);

  p_done_after_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(run_q));
  p_run_starts_at_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> cnt_q == '0);
endmodule

// File: rtl/mhf_bin_store.sv
module mhf_bin_store
  import mhf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             op_rem_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [NBINS-1:0] filter_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NBINS-1:0] zero_v;
  logic             err_q;

  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    logic [CNT_W-1:0] cnt_q;
    logic             bit_q;
    logic             sel;
    assign sel = upd_i && (idx_i == IDX_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        bit_q <= 1'b0;
      end else if (sel) begin
        if (!op_rem_i) begin
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
          if (cnt_q == '0) bit_q <= 1'b1;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) bit_q <= 1'b0;
        end
      end
    end

    assign zero_v[b]   = (cnt_q == '0);
    assign filter_o[b] = bit_q;

    p_bit_count_agree_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_q == (cnt_q != '0));
    p_saturate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel && !op_rem_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= upd_i && op_rem_i && zero_v[idx_i];
  end

  assign err_o = err_q;

  p_err_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> $past(upd_i && op_rem_i));
endmodule

// File: rtl/mhf_sync_tx.sv
module mhf_sync_tx
  import mhf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NBINS-1:0] filter_i,
  input  logic             acc_gnt_i,
  output logic             acc_req_o,
  output logic             wr_en_o,
  output logic [7:0]       wr_data_o,
  output logic             busy_o
);
  localparam int BYTE_W = $clog2(NBYTES);
  localparam logic [BYTE_W-1:0] LAST = BYTE_W'(NBYTES - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_TX} st_e;
  st_e              st_q;
  logic [BYTE_W-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      byte_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) st_q <= S_REQ;
        S_REQ: if (acc_gnt_i) begin
          st_q   <= S_TX;
          byte_q <= '0;
        end
        S_TX: begin
          byte_q <= byte_q + 1'b1;
          if (byte_q == LAST) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign acc_req_o = (st_q != S_IDLE);
  assign wr_en_o   = (st_q == S_TX);
  assign wr_data_o = wr_en_o ? filter_i[{byte_q, 3'b000} +: 8] : 8'h00;
  assign busy_o    = (st_q != S_IDLE);

  p_write_after_grant_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> $past(acc_gnt_i));
  p_req_during_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> acc_req_o);
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter bit LOOKUP_EN = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [1:0]  cmd_op_i,
  input  logic [47:0] cmd_addr_i,
  output logic        busy_o,
  output logic        err_o,
  output logic        acc_req_o,
  input  logic        acc_gnt_i,
  output logic        wr_en_o,
  output logic [7:0]  wr_data_o,
  input  logic        lookup_valid_i,
  input  logic [47:0] lookup_addr_i,
  output logic        lookup_hit_o
);
  op_e              op;
  logic             accept, hash_start, sync_start;
  logic             hash_busy_q, op_rem_q;
  logic             crc_done;
  logic [IDX_W-1:0] crc_idx;
  logic             upd;
  logic [NBINS-1:0] filter;
  logic             sync_busy;

  assign op         = op_e'(cmd_op_i);
  assign accept     = cmd_valid_i && !busy_o && (op != OP_NOP);
  assign hash_start = accept && (op == OP_ADD || op == OP_REM);
  assign sync_start = accept && (op == OP_SYNC);
  assign upd        = crc_done && hash_busy_q;
  assign busy_o     = hash_busy_q || sync_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hash_busy_q <= 1'b0;
      op_rem_q    <= 1'b0;
    end else if (hash_start) begin
      hash_busy_q <= 1'b1;
      op_rem_q    <= (op == OP_REM);
    end else if (upd) begin
      hash_busy_q <= 1'b0;
    end
  end

  mhf_crc_serial u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (hash_start),
    .addr_i  (cmd_addr_i),
    .done_o  (crc_done),
    .idx_o   (crc_idx)
  );

  mhf_bin_store #(.CNT_W(CNT_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd),
    .op_rem_i (op_rem_q),
    .idx_i    (crc_idx),
    .filter_o (filter),
    .err_o    (err_o)
  );

  mhf_sync_tx u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (sync_start),
    .filter_i  (filter),
    .acc_gnt_i (acc_gnt_i),
    .acc_req_o (acc_req_o),
    .wr_en_o   (wr_en_o),
    .wr_data_o (wr_data_o),
    .busy_o    (sync_busy)
  );

  if (LOOKUP_EN) begin : g_lookup
    logic hit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hit_q <= 1'b0;
      else         hit_q <= lookup_valid_i && filter[bin_of_addr(lookup_addr_i)];
    end
    assign lookup_hit_o = hit_q;
  end else begin : g_no_lookup
    assign lookup_hit_o = 1'b0;
  end

  p_accept_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && cmd_op_i != 2'b11) |=> busy_o);
  p_nop_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(cmd_valid_i && cmd_op_i != 2'b11)) |=> !busy_o);
  p_hit_needs_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_hit_o |-> $past(lookup_valid_i));
endmodule

// File: tb/mcast_hash_filter_tb.sv
module mcast_hash_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b11;
  logic [47:0] cmd_addr = '0;
  logic        busy, err, acc_req, wr_en, hit;
  logic        acc_gnt = 1'b0;
  logic [7:0]  wr_data;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_addr = '0;

  int n_chk = 0, n_fail = 0;
  int cnt_m [64];
  logic [63:0] filt_m = '0;

  always #5 clk = ~clk;

  mcast_hash_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .busy_o(busy), .err_o(err), .acc_req_o(acc_req),
    .acc_gnt_i(acc_gnt), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .lookup_valid_i(lk_valid), .lookup_addr_i(lk_addr), .lookup_hit_o(hit)
  );

  function automatic int hash_bin(input logic [47:0] a);
    logic [31:0] c;
    logic [15:0] w;
    logic d, fb;
    int r;
    c = 32'hFFFF_FFFF;
    for (int j = 2; j >= 0; j--) begin
      w = a[16*j +: 16];
      for (int k = 0; k < 16; k++) begin
        d  = (k < 8) ? w[8 + k] : w[k - 8];
        fb = c[31] ^ d;
        c  = c << 1;
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    end
    r = 0;
    for (int i = 0; i < 6; i++) if (c[i]) r = r | (1 << (5 - i));
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // add/remove; checks busy length and error pulse against the model
  task automatic do_op(input logic [1:0] op, input logic [47:0] a);
    int cyc, b;
    logic exp_err;
    b = hash_bin(a);
    exp_err = 1'b0;
    if (op == 2'b00) begin
      if (cnt_m[b] < 255) cnt_m[b]++;
    end else begin
      if (cnt_m[b] == 0) exp_err = 1'b1;
      else cnt_m[b]--;
    end
    filt_m[b] = (cnt_m[b] != 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b11;
    cyc = 0;
    while (busy && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
    chk("R7 busy length", 64'(cyc), 64'd49);
    chk(op == 2'b01 ? "R5 remove error pulse" : "R3 add no error", 64'(err), 64'(exp_err));
    @(negedge clk);
    chk("R5 error single cycle", 64'(err), 64'd0);
  endtask

  task automatic do_sync(input string req);
    logic [63:0] img;
    int d, n, m;
    img = '0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b11;
    chk("R8 request raised", 64'(acc_req), 64'd1);
    d = $urandom % 4;
    for (int i = 0; i < d; i++) begin
      chk("R8 no write before grant", 64'(wr_en), 64'd0);
      @(negedge clk);
    end
    acc_gnt = 1'b1;
    n = 0; m = 0;
    while (busy && m < 100) begin
      if (wr_en) begin
        img[8*n +: 8] = wr_data;
        n++;
      end
      m++;
      @(negedge clk);
      acc_gnt = 1'b0;
    end
    chk("R8 byte count", 64'(n), 64'd8);
    chk("R8 consecutive writes", 64'(m), 64'd9);
    chk(req, img, filt_m);
  endtask

  task automatic do_lookup(input logic [47:0] a);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R9 lookup hit", 64'(hit), 64'(filt_m[hash_bin(a)]));
    @(negedge clk);
    chk("R9 hit low without valid", 64'(hit), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [47:0] a, b2, c, pool [16];
    int ba, cyc;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) cnt_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 err after reset", 64'(err), 64'd0);
    chk("R1 req after reset", 64'(acc_req), 64'd0);
    chk("R1 write after reset", 64'(wr_en), 64'd0);
    chk("R1 hit after reset", 64'(hit), 64'd0);
    do_sync("R1 filter zero after reset");

    // R2 directed addresses, bit placement
    do_op(2'b00, 48'h0100_5E00_0001);
    do_sync("R2 bit placement");
    do_lookup(48'h0100_5E00_0001);
    do_op(2'b00, 48'hFFFF_FFFF_FFFF);
    do_op(2'b00, 48'h0000_0000_0000);
    do_op(2'b00, 48'h3333_0000_00FB);
    do_sync("R2 several bins");
    do_op(2'b01, 48'h0100_5E00_0001);
    do_op(2'b01, 48'hFFFF_FFFF_FFFF);
    do_op(2'b01, 48'h0000_0000_0000);
    do_op(2'b01, 48'h3333_0000_00FB);
    do_sync("R4 removed back to empty");

    // R4 shared bin via collision search
    a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
    ba = hash_bin(a);
    b2 = a;
    for (int t = 0; t < 20000; t++) begin
      b2 = {16'($urandom), $urandom};
      if (b2 != a && hash_bin(b2) == ba) break;
    end
    do_op(2'b00, a);
    do_op(2'b00, b2);
    do_op(2'b01, a);
    do_sync("R4 shared bin stays set");
    do_lookup(b2);
    do_op(2'b01, b2);
    do_sync("R4 last user clears bit");
    // R5 remove against zero
    do_op(2'b01, b2);
    do_sync("R5 filter unchanged after bad remove");

    // R7 commands ignored while busy, no-op ignored
    c = 48'h0100_5E7F_FFFA;
    b2 = c;
    for (int t = 0; t < 1000; t++) begin
      b2 = {16'($urandom), $urandom};
      if (hash_bin(b2) != hash_bin(c)) break;
    end
    cnt_m[hash_bin(c)]++; filt_m[hash_bin(c)] = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = c;
    @(negedge clk);
    cmd_addr = b2;
    cyc = 0;
    while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
    cmd_valid = 1'b0; cmd_op = 2'b11;
    chk("R7 busy length under pressure", 64'(cyc), 64'd49);
    do_sync("R7 command during busy ignored");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b11; cmd_addr = b2;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R7 no-op keeps idle", 64'(busy), 64'd0);
    do_op(2'b01, c);

    // R6 saturation
    c = 48'h0A0B_0C0D_0E0F;
    for (int i = 0; i < 256; i++) do_op(2'b00, c);
    do_lookup(c);
    for (int i = 0; i < 255; i++) do_op(2'b01, c);
    do_sync("R6 saturated bin cleared after 255 removes");
    do_op(2'b01, c);

    // random mix over a small pool
    for (int i = 0; i < 16; i++) pool[i] = {16'($urandom), $urandom};
    pool[15] = pool[3] ^ 48'h0000_0000_0001;
    for (int i = 0; i < 280; i++) begin
      int k;
      k = $urandom % 16;
      do_op(($urandom % 3 == 0) ? 2'b01 : 2'b00, pool[k]);
      if (i % 20 == 19) do_sync("R3 random mix filter image");
      if (i % 7 == 0) do_lookup(pool[$urandom % 16]);
    end
    do_sync("R4 final random image");
    finish_run();
  end
endmodule